// File: doc/BRIEF.md
# CAN Transmit Bit Monitor

This block watches the node's own transmissions on a CAN bus. At every sample strobe while the node is acting as transmitter, it compares the level the node drove with the level read back from the bus. A mismatch is sorted into one of two kinds:

- A **bit1 error** is a recessive bit that came back dominant.
- A **bit0 error** is a dominant bit that came back recessive.

Each kind sets its own sticky status flag. Every mismatch also raises a one-clock error pulse, which the protocol engine uses to start an error frame.

Some recessive-sent/dominant-read mismatches are legal on a CAN bus, so they are waived for bit1 errors only:

- inside the arbitration field, where losing arbitration is normal;
- in the ACK slot, where receivers drive dominant;
- while the node sends a passive error flag.

Dominant-sent/recessive-read mismatches are never waived. Software acknowledges a status read with a one-cycle read-acknowledge, which clears both sticky flags.

Top module: `can_tx_bit_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, `bit1_err`, `bit0_err` and `err_pulse` are 0 after that edge.
- R2: A strobe with `tx_active`=1, `tx_bit`=1 (recessive), `rx_bit`=0 (dominant) and no waiver context sets `bit1_err` at that clock edge. `bit0_err` is left unchanged.
- R3: A strobe with `tx_active`=1, `tx_bit`=0, `rx_bit`=1 sets `bit0_err` at that clock edge, whatever the context inputs are. `bit1_err` is left unchanged.
- R4: Without `sample_stb`=1, no mismatch sets a flag or raises `err_pulse`.
- R5: With `tx_active`=0, no mismatch sets a flag or raises `err_pulse`.
- R6: With `in_arb`=1, a recessive-sent/dominant-read mismatch sets no flag and raises no pulse.
- R7: With `in_ack_slot`=1, a recessive-sent/dominant-read mismatch sets no flag and raises no pulse.
- R8: With `in_pass_err_flag`=1, a recessive-sent/dominant-read mismatch sets no flag and raises no pulse.
- R9: `rd_ack`=1 at a clock edge clears both flags after that edge, unless R10 applies.
- R10: If a new error of one kind is detected at the same edge as `rd_ack`, that kind's flag is 1 after the edge. The other kind's flag is cleared.
- R11: `err_pulse` is 1 in the cycle after each strobe that reports an error (R2/R3) and 0 in every other cycle. Two such strobes in a row give two consecutive pulse cycles.
- R12: A strobe where `tx_bit` equals `rx_bit` sets no flag and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Bit sample point strobe |
| tx_active | input | 1 | Node is currently the transmitter |
| tx_bit | input | 1 | Level driven by the node (1 = recessive) |
| rx_bit | input | 1 | Level sampled from the bus (1 = recessive) |
| in_arb | input | 1 | Current bit lies in the arbitration field |
| in_ack_slot | input | 1 | Current bit is the ACK slot |
| in_pass_err_flag | input | 1 | Node is sending a passive error flag |
| rd_ack | input | 1 | Status-read acknowledge; clears the sticky flags |
| bit1_err | output | 1 | Sticky: recessive sent, dominant read |
| bit0_err | output | 1 | Sticky: dominant sent, recessive read |
| err_pulse | output | 1 | One-clock pulse per detected mismatch |

## Verification
The bench drives each waiver context with both mismatch directions. A design that waived the wrong direction would either miss bit0 errors during arbitration, the ACK slot or a passive error flag, or flag legal arbitration losses. It collides a read-acknowledge with a fresh error to catch a clear that wins over a set, and checks that the other flag still clears. Back-to-back mismatching strobes, followed by a matching one, expose a pulse that is stretched, merged or missing. Mismatches without a strobe or without transmitter role must leave every output quiet.

// File: rtl/can_bitmon_pkg.sv
package can_bitmon_pkg;

    // Number of independent sticky flags and their slots
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_BIT1 = 0;
    localparam int unsigned FLAG_BIT0 = 1;

    typedef enum logic [1:0] {
        MM_NONE = 2'd0,
        MM_BIT1 = 2'd1,
        MM_BIT0 = 2'd2
    } mm_kind_e;

    typedef struct packed {
        logic arb;
        logic ack_slot;
        logic pass_flag;
    } frame_ctx_t;

    typedef struct packed {
        logic       strobe;
        logic       driving;
        logic       tx_lvl;
        logic       rx_lvl;
        frame_ctx_t ctx;
    } bit_obs_t;

    // Contexts in which a dominant read-back of a recessive bit is legal
    function automatic logic bit1_waived(input frame_ctx_t c);
        return c.arb | c.ack_slot | c.pass_flag;
    endfunction

    function automatic mm_kind_e classify(input bit_obs_t o);
        mm_kind_e k;
        k = MM_NONE;
        if (o.strobe && o.driving) begin
            if (o.tx_lvl && !o.rx_lvl && !bit1_waived(o.ctx))
                k = MM_BIT1;
            else if (!o.tx_lvl && o.rx_lvl)
                k = MM_BIT0;
        end
        return k;
    endfunction

endpackage

// File: rtl/cbm_classifier.sv
module cbm_classifier
    import can_bitmon_pkg::*;
(
    input  bit_obs_t             obs_i,
    output mm_kind_e             kind_o,
    output logic [NUM_FLAGS-1:0] hit_o
);
    always_comb begin
        kind_o = classify(obs_i);
        hit_o  = '0;
        hit_o[FLAG_BIT1] = (kind_o == MM_BIT1);
        hit_o[FLAG_BIT0] = (kind_o == MM_BIT0);
    end
endmodule

// File: rtl/cbm_pulse_gen.sv
module cbm_pulse_gen
    import can_bitmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic [NUM_FLAGS-1:0] hit_i,
    output logic                 pulse_o
);
    always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= |hit_i;
    end

    // A pulse only follows a sampled bit (R4, R11)
    p_pulse_needs_sample_r4: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(sample_i));
    // Each hit yields a pulse in the next cycle (R11)
    p_pulse_after_hit_r11: assert property (@(posedge clk) disable iff (rst)
        (|hit_i) |=> pulse_o);
endmodule

// File: rtl/cbm_sticky_flag.sv
module cbm_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // A set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/can_tx_bit_monitor.sv
module can_tx_bit_monitor
    import can_bitmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_stb,
    input  logic tx_active,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic in_arb,
    input  logic in_ack_slot,
    input  logic in_pass_err_flag,
    input  logic rd_ack,
    output logic bit1_err,
    output logic bit0_err,
    output logic err_pulse
);
    bit_obs_t             obs;
    mm_kind_e             kind;
    logic [NUM_FLAGS-1:0] hit;
    logic [NUM_FLAGS-1:0] flags;

    always_comb begin
        obs.strobe        = sample_stb;
        obs.driving       = tx_active;
        obs.tx_lvl        = tx_bit;
        obs.rx_lvl        = rx_bit;
        obs.ctx.arb       = in_arb;
        obs.ctx.ack_slot  = in_ack_slot;
        obs.ctx.pass_flag = in_pass_err_flag;
    end

    cbm_classifier u_classifier (
        .obs_i  (obs),
        .kind_o (kind),
        .hit_o  (hit)
    );

    cbm_pulse_gen u_pulse (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_stb & tx_active),
        .hit_i    (hit),
        .pulse_o  (err_pulse)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        cbm_sticky_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (hit[g]),
            .clr_i  (rd_ack),
            .flag_o (flags[g])
        );
    end

    assign bit1_err = flags[FLAG_BIT1];
    assign bit0_err = flags[FLAG_BIT0];

    // Port-level checks
    p_bit1_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bit1_err) |-> $past(sample_stb && tx_active && tx_bit && !rx_bit));
    p_bit1_waiver_r6_r7_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(bit1_err) |-> $past(!in_arb && !in_ack_slot && !in_pass_err_flag));
    p_bit0_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bit0_err) |-> $past(sample_stb && tx_active && !tx_bit && rx_bit));
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !tx_active |=> !err_pulse);
    p_exclusive_kind_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
    p_kind_matches_r12: assert property (@(posedge clk) disable iff (rst)
        (kind != MM_NONE) |-> (tx_bit != rx_bit));
endmodule

// File: tb/can_tx_bit_monitor_bench.sv
`timescale 1ns/1ps
module can_tx_bit_monitor_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 0, tx_active = 0, tx_bit = 1, rx_bit = 1;
    logic in_arb = 0, in_ack_slot = 0, in_pass_err_flag = 0, rd_ack = 0;
    logic bit1_err, bit0_err, err_pulse;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk; // 125 MHz

    can_tx_bit_monitor u_can_tx_bit_monitor (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .tx_active(tx_active),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .in_arb(in_arb), .in_ack_slot(in_ack_slot),
        .in_pass_err_flag(in_pass_err_flag), .rd_ack(rd_ack),
        .bit1_err(bit1_err), .bit0_err(bit0_err), .err_pulse(err_pulse)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e1, input logic e0, input logic ep);
        chk(req, "bit1_err", bit1_err, e1);
        chk(req, "bit0_err", bit0_err, e0);
        chk(req, "err_pulse", err_pulse, ep);
    endtask

    // Drive one cycle of inputs at the falling edge, return at the next falling edge
    task automatic cyc(input logic stb, input logic act, input logic tb, input logic rb,
                       input logic arb, input logic ack, input logic pas, input logic rda);
        sample_stb = stb; tx_active = act; tx_bit = tb; rx_bit = rb;
        in_arb = arb; in_ack_slot = ack; in_pass_err_flag = pas; rd_ack = rda;
        @(posedge clk);
        @(negedge clk);
        sample_stb = 0; rd_ack = 0;
    endtask

    task automatic idle();
        cyc(0, 0, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic clear_flags();
        cyc(0, 0, 1, 1, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 0, 0);
        // Errors during reset are discarded
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        chk_all("R1", 0, 0, 0);
        rst = 0;
        idle();
        chk_all("R1", 0, 0, 0);
    endtask

    task automatic t_bit1();
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        chk_all("R2", 1, 0, 1);
        idle();
        chk_all("R11", 1, 0, 0);
        clear_flags();
        chk_all("R9", 0, 0, 0);
    endtask

    task automatic t_bit0();
        cyc(1, 1, 0, 1, 0, 0, 0, 0);
        chk_all("R3", 0, 1, 1);
        idle();
        chk_all("R11", 0, 1, 0);
        // bit0 errors are flagged in every waiver context
        clear_flags();
        cyc(1, 1, 0, 1, 1, 1, 1, 0);
        chk_all("R3", 0, 1, 1);
        clear_flags();
        chk_all("R9", 0, 0, 0);
    endtask

    task automatic t_match();
        cyc(1, 1, 1, 1, 0, 0, 0, 0);
        chk_all("R12", 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0);
        chk_all("R12", 0, 0, 0);
    endtask

    task automatic t_no_strobe();
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        chk_all("R4", 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        chk_all("R4", 0, 0, 0);
    endtask

    task automatic t_not_tx();
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        chk_all("R5", 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0, 0);
        chk_all("R5", 0, 0, 0);
    endtask

    task automatic t_waive(input string req, input logic arb, input logic ack, input logic pas);
        cyc(1, 1, 1, 0, arb, ack, pas, 0);
        chk_all(req, 0, 0, 0);
        cyc(1, 1, 0, 1, arb, ack, pas, 0);
        chk_all(req, 0, 1, 1);
        clear_flags();
    endtask

    task automatic t_collide();
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 0, 0);
        chk_all("R11", 1, 1, 1);
        // read-ack together with a new bit1 error: bit1 stays, bit0 clears
        cyc(1, 1, 1, 0, 0, 0, 0, 1);
        chk_all("R10", 1, 0, 1);
        clear_flags();
        chk_all("R9", 0, 0, 0);
        // read-ack with a new bit0 error
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 0, 1);
        chk_all("R10", 0, 1, 1);
        clear_flags();
    endtask

    task automatic t_back_to_back();
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R11", "pulse1", err_pulse, 1);
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R11", "pulse2", err_pulse, 1);
        cyc(1, 1, 1, 1, 0, 0, 0, 0);
        chk("R11", "pulse_after_match", err_pulse, 0);
        idle();
        chk("R11", "pulse_idle", err_pulse, 0);
        clear_flags();
        chk_all("R9", 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_bit1();
        t_bit0();
        t_match();
        t_no_strobe();
        t_not_tx();
        t_waive("R6", 1, 0, 0);
        t_waive("R7", 0, 1, 0);
        t_waive("R8", 0, 0, 1);
        t_collide();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule